// File: doc/BRIEF.md
# Receive-Only Two-Wire Bus Slave Front End

This block lets a chip act as a write-only target on an I2C-compatible two-wire bus. A fast system clock samples the clock and data lines. Each line is synchronised and then filtered by a counter, so that it ignores pulses shorter than a set number of system clocks. The filtered lines go to a detector that finds START, repeated START and STOP conditions. A byte engine then shifts in bytes MSB first, checks the first byte of each frame against the block's own address, and pulls the data line low through an output enable during the acknowledge clock.

The address has seven bits. Its top three bits are the constant 010, and the lower four come from strap pins. A mode input replaces the upper two strap bits with ones, which leaves four usable addresses.

The block acknowledges and delivers data only after its address matched with the write bit clear. The back end then receives, for each data byte:
- a one-cycle valid strobe;
- the byte itself;
- its position in the frame.

A STOP or a repeated START that ends an addressed frame raises its own strobe. With that strobe the block reports how many bits of an unfinished byte had arrived, so that the back end can discard the fragment.

Top module: `twi_rx_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `addressed_o` are 0 and no strobe (`rx_valid_o`, `stop_o`, `abort_o`) is raised while the bus stays idle with both lines high.
- R2: A START (filtered SDA falls while SCL is high) begins a frame. The first byte is then compared with the own address, which is bits 7..1 of that byte. The own address is `{3'b010, strap_i[3:0]}` when `two_strap_i` is 0, and `{3'b010, 2'b11, strap_i[1:0]}` when it is 1.
- R3: An address byte whose bit 0 is 1 (a read request), or whose bits 7..1 do not match, is not acknowledged. The rest of that frame yields no `rx_valid_o`, no `stop_o` and no `abort_o`.
- R4: After a matching address byte, and after every data byte of an addressed frame, `sda_oe_o` is 1 during the ninth SCL high phase. It returns to 0 on the SCL fall that ends the ninth clock.
- R5: Data bytes are taken MSB first. Each one is presented with a single-cycle `rx_valid_o`, the byte on `rx_data_o`, and `rx_index_o`. The index counts 0, 1, 2, ... from the first data byte after the address.
- R6: A STOP (filtered SDA rises while SCL is high) during an addressed frame gives a single-cycle `stop_o` and clears `addressed_o`. A STOP in a frame that was not addressed gives no `stop_o`.
- R7: A START during an addressed frame gives a single-cycle `abort_o` and clears `addressed_o`. The next byte is then checked as a new address.
- R8: With `stop_o` or `abort_o`, `end_bits_o` gives the number of bits (0..7) of the current byte that had fully completed, each counted on its SCL fall. A partial byte never yields `rx_valid_o`.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks has no effect on the received data, the acknowledge, or the frame state.
- R10: `sda_oe_o` changes only while the filtered SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 4 | Address strap pins, low address nibble |
| two_strap_i | input | 1 | 1: strap bits 3..2 are taken as ones |
| sda_oe_o | output | 1 | 1: pull the data line low (acknowledge) |
| rx_valid_o | output | 1 | Single-cycle strobe: a data byte is ready |
| rx_data_o | output | 8 | Received data byte |
| rx_index_o | output | IDX_W | Position of the byte in the frame |
| stop_o | output | 1 | STOP ended an addressed frame |
| abort_o | output | 1 | START interrupted an addressed frame |
| end_bits_o | output | 3 | Bits of the unfinished byte at stop or abort |
| addressed_o | output | 1 | The current frame carries the own address |

## Verification
On every cycle, the assertions check the following:
- the acknowledge enable is raised only in the acknowledge slot of an addressed frame;
- it changes only while SCL is low;
- data, STOP and abort strobes appear only in addressed frames;
- the filter output moves only to a value the synchronised input has held.

The following can only be shown by the bench scenarios:
- the address decoding across the strap patterns and both strap modes;
- MSB-first byte assembly and the running index;
- the partial-bit count when a frame is cut short;
- the rejection of short pulses on both lines.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } twi_state_e;

  localparam logic [2:0] TWI_PREFIX = 3'b010;

  // Own 7-bit address from the straps and the strap mode.
  function automatic logic [6:0] twi_own_addr(input logic [3:0] strap,
                                              input logic       two_strap);
    logic [3:0] low;
    low = two_strap ? {2'b11, strap[1:0]} : strap;
    return {TWI_PREFIX, low};
  endfunction

  // An address byte is accepted when its upper seven bits match and the
  // direction bit asks for a write.
  function automatic logic twi_addr_hit(input logic [7:0] rx_byte,
                                        input logic [6:0] own);
    return (rx_byte[7:1] == own) && !rx_byte[0];
  endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int STABLE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] diff_cnt;
  logic             sync_w;

  assign sync_w = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      diff_cnt <= '0;
      line_o   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_w == line_o) begin
        diff_cnt <= '0;
      end else if (diff_cnt == CNT_LAST) begin
        line_o   <= sync_w;
        diff_cnt <= '0;
      end else begin
        diff_cnt <= diff_cnt + 1'b1;
      end
    end
  end

  // R9: the filtered line only ever moves to the synchronised value
  assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o != $past(line_o)) |-> ($past(sync_w) == line_o));

  assert_filter_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    diff_cnt < CNT_W'(STABLE_CYCLES));

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  // SDA moving while SCL is held high marks a frame boundary
  assign start_o    = scl_f_i && scl_q && sda_q && !sda_f_i;
  assign stop_o     = scl_f_i && scl_q && !sda_q && sda_f_i;
  assign scl_rise_o = scl_f_i && !scl_q;
  assign scl_fall_o = !scl_f_i && scl_q;

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_rx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             scl_f_i,
  input  logic             sda_f_i,
  input  logic [6:0]       own_addr_i,
  output logic             sda_oe_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic [IDX_W-1:0] rx_index_o,
  output logic             stop_o,
  output logic             abort_o,
  output logic [2:0]       end_bits_o,
  output logic             addressed_o
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd7;

  twi_state_e       state;
  logic [3:0]       bit_cnt;
  logic             bit_pend;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] next_idx;
  logic             in_frame;
  logic [2:0]       partial_w;
  logic             byte_done_w;
  logic             ack_done_w;

  assign in_frame    = (state == ST_ADDR) || (state == ST_DATA);
  assign partial_w   = (bit_cnt == ACK_SLOT) ? 3'd0 : bit_cnt[2:0];
  assign byte_done_w = in_frame && scl_fall_i && bit_pend && (bit_cnt == LAST_BIT);
  assign ack_done_w  = in_frame && scl_fall_i && bit_pend && (bit_cnt == ACK_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      bit_pend    <= 1'b0;
      shreg       <= '0;
      next_idx    <= '0;
      sda_oe_o    <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_data_o   <= '0;
      rx_index_o  <= '0;
      stop_o      <= 1'b0;
      abort_o     <= 1'b0;
      end_bits_o  <= '0;
      addressed_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      stop_o     <= 1'b0;
      abort_o    <= 1'b0;
      if (start_i) begin
        if (addressed_o) begin
          abort_o    <= 1'b1;
          end_bits_o <= partial_w;
        end
        state       <= ST_ADDR;
        bit_cnt     <= '0;
        bit_pend    <= 1'b0;
        next_idx    <= '0;
        sda_oe_o    <= 1'b0;
        addressed_o <= 1'b0;
      end else if (stop_i) begin
        if (addressed_o) begin
          stop_o     <= 1'b1;
          end_bits_o <= partial_w;
        end
        state       <= ST_IDLE;
        bit_cnt     <= '0;
        bit_pend    <= 1'b0;
        sda_oe_o    <= 1'b0;
        addressed_o <= 1'b0;
      end else if (in_frame) begin
        if (scl_rise_i) begin
          bit_pend <= 1'b1;
          if (bit_cnt < ACK_SLOT) shreg <= {shreg[6:0], sda_f_i};
        end else if (ack_done_w) begin
          bit_pend <= 1'b0;
          sda_oe_o <= 1'b0;
          bit_cnt  <= '0;
        end else if (byte_done_w) begin
          bit_pend <= 1'b0;
          if (state == ST_ADDR) begin
            if (twi_addr_hit(shreg, own_addr_i)) begin
              state       <= ST_DATA;
              addressed_o <= 1'b1;
              sda_oe_o    <= 1'b1;
              bit_cnt     <= ACK_SLOT;
            end else begin
              state   <= ST_SKIP;
              bit_cnt <= '0;
            end
          end else begin
            rx_valid_o <= 1'b1;
            rx_data_o  <= shreg;
            rx_index_o <= next_idx;
            next_idx   <= next_idx + 1'b1;
            sda_oe_o   <= 1'b1;
            bit_cnt    <= ACK_SLOT;
          end
        end else if (scl_fall_i && bit_pend) begin
          bit_pend <= 1'b0;
          bit_cnt  <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R4: the line is pulled only in the acknowledge slot of an addressed frame
  assert_ack_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (addressed_o && (bit_cnt == ACK_SLOT)));

  // R10: the enable rises only while SCL is low
  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_f_i);

  // R10: the enable falls only while SCL is low, unless a START or STOP released it
  assert_oe_fall_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_f_i);

  assert_valid_addressed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> addressed_o);

  assert_stop_addressed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> ($past(addressed_o) && !addressed_o));

  assert_abort_addressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> ($past(addressed_o) && (state == ST_ADDR)));

  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid_o, stop_o, abort_o}));

endmodule

// File: rtl/twi_rx_slave.sv
module twi_rx_slave
  import twi_rx_pkg::*;
#(
  parameter int FILT_CYCLES = 10,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [3:0]       strap_i,
  input  logic             two_strap_i,
  output logic             sda_oe_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic [IDX_W-1:0] rx_index_o,
  output logic             stop_o,
  output logic             abort_o,
  output logic [2:0]       end_bits_o,
  output logic             addressed_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_w;
  logic [N_LINES-1:0] filt_w;
  logic start_w, stop_w, scl_rise_w, scl_fall_w;
  logic [6:0] own_addr_w;

  assign raw_w      = {sda_i, scl_i};
  assign own_addr_w = twi_own_addr(strap_i, two_strap_i);

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    twi_line_filter #(.STABLE_CYCLES(FILT_CYCLES)) filt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_w[g]),
      .line_o (filt_w[g])
    );
  end

  twi_cond_detect det_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f_i    (filt_w[0]),
    .sda_f_i    (filt_w[1]),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w)
  );

  twi_byte_engine #(.IDX_W(IDX_W)) eng_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .scl_rise_i  (scl_rise_w),
    .scl_fall_i  (scl_fall_w),
    .scl_f_i     (filt_w[0]),
    .sda_f_i     (filt_w[1]),
    .own_addr_i  (own_addr_w),
    .sda_oe_o    (sda_oe_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .rx_index_o  (rx_index_o),
    .stop_o      (stop_o),
    .abort_o     (abort_o),
    .end_bits_o  (end_bits_o),
    .addressed_o (addressed_o)
  );

endmodule

// File: tb/twi_rx_slave_tb.sv
`timescale 1ns/1ps
module twi_rx_slave_tb_top;
  localparam int Q = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'd0;
  logic two_strap = 1'b0;
  logic sda_oe, rx_valid, stop_s, abort_s, addressed;
  logic [7:0] rx_data;
  logic [3:0] rx_index;
  logic [2:0] end_bits;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int n_rx = 0;
  int stop_cnt = 0;
  int abort_cnt = 0;
  int last_end = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] rx_log [0:7];
  int idx_log [0:7];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_rx_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .two_strap_i(two_strap),
    .sda_oe_o(sda_oe), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_index_o(rx_index), .stop_o(stop_s), .abort_o(abort_s),
    .end_bits_o(end_bits), .addressed_o(addressed)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin
      rx_log[n_rx % 8]  <= rx_data;
      idx_log[n_rx % 8] <= int'(rx_index);
      n_rx <= n_rx + 1;
    end
    if (stop_s) begin stop_cnt <= stop_cnt + 1; last_end <= int'(end_bits); end
    if (abort_s) begin abort_cnt <= abort_cnt + 1; last_end <= int'(end_bits); end
    if (cyc > 195000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual %0d expected <195000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  // bit with a short SDA pulse and a short SCL dip inside the high phase
  task automatic send_bit_glitchy(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(10);
    sda_m = ~b; tick(6); sda_m = b; tick(14);
    scl_m = 1'b0; tick(6); scl_m = 1'b1; tick(24);
    scl_m = 1'b0; tick(Q);
  endtask

  // sends 8 bits MSB first, then the ack clock; returns the ack seen and
  // whether the line was released after the ack clock
  task automatic send_byte(input logic [7:0] b, input bit glitchy,
                           output bit acked, output bit released);
    for (int i = 7; i >= 0; i--) begin
      if (glitchy) send_bit_glitchy(b[i]); else send_bit(b[i]);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q); scl_m = 1'b0; tick(Q);
    released = (sda_oe == 1'b0);
  endtask

  function automatic int own_of(input int s, input bit mode);
    return mode ? (32 + 12 + (s % 4)) : (32 + s);
  endfunction

  initial begin
    bit ack, rel;
    int base, sbase, abase, own;
    tick(10);
    check(sda_oe == 0 && addressed == 0, "R1 reset outputs", int'({sda_oe, addressed}), 0);
    rst_n = 1'b1;
    tick(100);
    check(n_rx == 0 && stop_cnt == 0 && abort_cnt == 0, "R1 idle no strobes",
          n_rx + stop_cnt + abort_cnt, 0);

    // R2 sweep of the low address nibble across strap configurations
    for (int c = 0; c < 3; c++) begin
      strap     = (c == 0) ? 4'b0101 : (c == 1) ? 4'b1010 : 4'b0010;
      two_strap = (c == 2);
      own = own_of(int'(strap), two_strap);
      for (int k = 0; k < 17; k++) begin
        int cand;
        bit exp;
        cand = (k < 16) ? (32 + k) : (own ^ 7'h40);
        exp  = (cand == own);
        sbase = stop_cnt;
        bus_start();
        send_byte({cand[6:0], 1'b0}, 1'b0, ack, rel);
        check(ack == exp, "R2 address ack", int'(ack), int'(exp));
        check(addressed == exp, "R2 addressed flag", int'(addressed), int'(exp));
        bus_stop();
        check((stop_cnt - sbase) == int'(exp), "R6 stop only when addressed",
              stop_cnt - sbase, int'(exp));
      end
    end

    strap = 4'b0110; two_strap = 1'b0;
    own = own_of(6, 1'b0);

    // R3 read request is refused and the frame ignored
    base = n_rx; sbase = stop_cnt;
    bus_start();
    send_byte({own[6:0], 1'b1}, 1'b0, ack, rel);
    check(ack == 0, "R3 read not acked", int'(ack), 0);
    send_byte(8'h5A, 1'b0, ack, rel);
    check(ack == 0 && n_rx == base, "R3 bytes ignored", n_rx - base, 0);
    bus_stop();
    check(stop_cnt == sbase && addressed == 0, "R3 no stop strobe", stop_cnt - sbase, 0);

    // R4 R5 R6 three data bytes
    base = n_rx; sbase = stop_cnt;
    bus_start();
    send_byte({own[6:0], 1'b0}, 1'b0, ack, rel);
    check(ack && rel, "R4 address ack and release", int'({ack, rel}), 3);
    send_byte(8'hA5, 1'b0, ack, rel);
    check(ack && rel, "R4 data ack and release", int'({ack, rel}), 3);
    send_byte(8'h3C, 1'b0, ack, rel);
    send_byte(8'hFF, 1'b0, ack, rel);
    check(n_rx - base == 3, "R5 byte count", n_rx - base, 3);
    check(rx_log[base % 8] == 8'hA5, "R5 byte0", int'(rx_log[base % 8]), 'hA5);
    check(rx_log[(base + 1) % 8] == 8'h3C, "R5 byte1", int'(rx_log[(base + 1) % 8]), 'h3C);
    check(rx_log[(base + 2) % 8] == 8'hFF, "R5 byte2", int'(rx_log[(base + 2) % 8]), 'hFF);
    check(idx_log[(base + 2) % 8] == 2 && idx_log[base % 8] == 0, "R5 index",
          idx_log[(base + 2) % 8], 2);
    bus_stop();
    check(stop_cnt - sbase == 1 && last_end == 0, "R6 stop strobe", stop_cnt - sbase, 1);
    check(addressed == 0, "R6 addressed cleared", int'(addressed), 0);

    // R8 partial byte at STOP
    base = n_rx; sbase = stop_cnt;
    bus_start();
    send_byte({own[6:0], 1'b0}, 1'b0, ack, rel);
    send_byte(8'h11, 1'b0, ack, rel);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    check(n_rx - base == 1, "R8 partial not delivered", n_rx - base, 1);
    check(stop_cnt - sbase == 1 && last_end == 5, "R8 end bits at stop", last_end, 5);

    // R7 repeated START aborts, then another address is refused
    base = n_rx; sbase = stop_cnt; abase = abort_cnt;
    bus_start();
    send_byte({own[6:0], 1'b0}, 1'b0, ack, rel);
    send_byte(8'h77, 1'b0, ack, rel);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_rstart();
    check(abort_cnt - abase == 1 && addressed == 0, "R7 abort strobe", abort_cnt - abase, 1);
    check(last_end == 3, "R8 end bits at abort", last_end, 3);
    send_byte({own[6:0] ^ 7'h01, 1'b0}, 1'b0, ack, rel);
    check(ack == 0, "R7 new address rechecked", int'(ack), 0);
    bus_stop();
    check(stop_cnt == sbase && n_rx - base == 1, "R7 no stop after abort", stop_cnt - sbase, 0);

    // R9 short pulses on both lines inside data bits
    base = n_rx; sbase = stop_cnt; abase = abort_cnt;
    bus_start();
    send_byte({own[6:0], 1'b0}, 1'b0, ack, rel);
    send_byte(8'hC3, 1'b1, ack, rel);
    check(ack == 1, "R9 glitchy byte acked", int'(ack), 1);
    check(n_rx - base == 1 && rx_log[base % 8] == 8'hC3, "R9 glitchy byte value",
          int'(rx_log[base % 8]), 'hC3);
    check(abort_cnt == abase && stop_cnt == sbase && addressed == 1, "R9 no false condition",
          abort_cnt - abase + stop_cnt - sbase, 0);
    bus_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule